// File: doc/BRIEF.md
# Raster Line Interrupt Generator

This block turns the sync outputs of a video timing controller into a periodic interrupt request for the CPU. It counts scan lines on the falling edge of horizontal sync. Every fifty-two lines it raises a request. Every frame it realigns its line count to vertical sync, so the interrupts keep a fixed phase against the picture.

Two lines after vertical sync begins, the line count is forced back to zero. If fewer than thirty-two lines had gone by since the last periodic request, an extra request is raised at that point. The request is a level that stays high until the CPU acknowledges it. An acknowledge also drops the upper half of the count range. Software can zero the count with a strobe.

Top module: `raster_irq_gen`

## Requirements
- R1: The line count advances by one only on a cycle where hsyncIn is low and was high on the previous clock. In any cycle with no such fall, no acknowledge and no clear, the count holds.
- R2: A fall that brings the count to 52 sets irqOut on the next clock and returns the count to 0. Starting from 0, the 52nd fall is the first one to raise the request.
- R3: A cycle where vsyncIn is high and was low on the previous clock loads a two-line delay.
- R4: While the delay is nonzero, each hsync fall decrements it. The fall that brings it to zero leaves the line count at 0 after its own increment.
- R5: At the fall of R4, irqOut is set if the count after that fall's increment is below 32. At 32 or above, no request is raised.
- R6: intAck clears irqOut on the next clock, unless a request is raised in the same cycle. It also clears bit 5 of the line count and keeps the other bits.
- R7: cntClear forces the line count to 0 on the next clock. It takes effect after any increment, resynchronisation or acknowledge in the same cycle.
- R8: Once set, irqOut stays high until an acknowledge.
- R9: The synchronous active-high rst clears the line count, the delay and irqOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| hsyncIn | input | 1 | Horizontal sync from the timing controller |
| vsyncIn | input | 1 | Vertical sync from the timing controller |
| intAck | input | 1 | One-cycle CPU interrupt acknowledge |
| cntClear | input | 1 | One-cycle software strobe that zeroes the line count |
| irqOut | output | 1 | Level interrupt request |

## Verification
Each result follows the clock edge that samples its cause. A request raised by an hsync fall, and a request cleared by intAck, both appear on irqOut one clock after the cycle in which the fall or the acknowledge is presented.

The bench drives every input on the falling clock edge. It steps its reference model once per cycle and compares irqOut on the next falling edge, after exactly one register stage. Since the line count is internal, counter effects (bit 5 clearing, the software clear, resynchronisation) are checked by counting falls until the next request.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic lineStep;   // hsync trailing edge seen
    logic resync;     // delay expires on this line step
    logic ack;        // CPU acknowledge
    logic zap;        // software count clear
  } ctrlStrobes_t;

endpackage

// File: rtl/raster_sync_edge.sv
module raster_sync_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic sigIn,
  output logic edgeOut
);

  logic sigDly;

  // Sampled every clock, also during reset, so the edge is valid at once
  always_ff @(posedge clk) begin
    sigDly <= sigIn;
  end

  generate
    if (RISING) begin : g_rise
      assign edgeOut = sigIn & ~sigDly;
    end else begin : g_fall
      assign edgeOut = sigDly & ~sigIn;
    end
  endgenerate

endmodule

// File: rtl/raster_irq_ctrl.sv
module raster_irq_ctrl
  import raster_irq_pkg::*;
#(
  parameter int DELAY_LOAD = 2,
  localparam int DELAY_W = $clog2(DELAY_LOAD + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hsyncIn,
  input  logic               vsyncIn,
  input  logic               intAck,
  input  logic               cntClear,
  output ctrlStrobes_t       strobes,
  output logic [DELAY_W-1:0] delayCnt
);

  logic hsFall;
  logic vsRise;
  logic [DELAY_W-1:0] delayNext;

  raster_sync_edge #(.RISING(1'b0)) hsEdge_i (
    .clk(clk), .sigIn(hsyncIn), .edgeOut(hsFall)
  );

  raster_sync_edge #(.RISING(1'b1)) vsEdge_i (
    .clk(clk), .sigIn(vsyncIn), .edgeOut(vsRise)
  );

  always_comb begin
    delayNext = delayCnt;
    if (hsFall && delayCnt != '0) delayNext = delayCnt - 1'b1;
    // A new frame start reloads after any decrement in the same cycle
    if (vsRise) delayNext = DELAY_W'(DELAY_LOAD);
  end

  always_ff @(posedge clk) begin
    if (rst) delayCnt <= '0;
    else     delayCnt <= delayNext;
  end

  always_comb begin
    strobes.lineStep = hsFall;
    strobes.resync   = hsFall && (delayCnt == DELAY_W'(1));
    strobes.ack      = intAck;
    strobes.zap      = cntClear;
  end

endmodule

// File: rtl/raster_irq_dpath.sv
module raster_irq_dpath
  import raster_irq_pkg::*;
#(
  parameter int WRAP_AT   = 52,
  parameter int LOW_LIMIT = 32,
  parameter int ACK_BIT   = 5,
  localparam int LINE_W = $clog2(WRAP_AT)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  output logic [LINE_W-1:0] lineCnt,
  output logic              irqOut
);

  logic [LINE_W:0]   incWide;
  logic [LINE_W-1:0] stepped;
  logic [LINE_W-1:0] lineNext;
  logic              wrapHit;
  logic              lowHit;
  logic              raiseReq;

  always_comb begin
    incWide  = {1'b0, lineCnt} + 1'b1;
    wrapHit  = strobes.lineStep && (incWide == (LINE_W+1)'(WRAP_AT));
    stepped  = lineCnt;
    if (strobes.lineStep) stepped = wrapHit ? '0 : incWide[LINE_W-1:0];
    lowHit   = strobes.resync && ({1'b0, stepped} < (LINE_W+1)'(LOW_LIMIT));
    raiseReq = wrapHit || lowHit;

    lineNext = strobes.resync ? '0 : stepped;
    if (strobes.ack) lineNext[ACK_BIT] = 1'b0;
    if (strobes.zap) lineNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineCnt <= '0;
      irqOut  <= 1'b0;
    end else begin
      lineCnt <= lineNext;
      if (raiseReq)         irqOut <= 1'b1;
      else if (strobes.ack) irqOut <= 1'b0;
    end
  end

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import raster_irq_pkg::*;
#(
  parameter int WRAP_AT    = 52,
  parameter int LOW_LIMIT  = 32,
  parameter int ACK_BIT    = 5,
  parameter int DELAY_LOAD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hsyncIn,
  input  logic vsyncIn,
  input  logic intAck,
  input  logic cntClear,
  output logic irqOut
);

  localparam int LINE_W  = $clog2(WRAP_AT);
  localparam int DELAY_W = $clog2(DELAY_LOAD + 1);

  ctrlStrobes_t        strobes;
  logic [LINE_W-1:0]   lineCnt;
  logic [DELAY_W-1:0]  delayCnt;

  raster_irq_ctrl #(.DELAY_LOAD(DELAY_LOAD)) ctrl_i (
    .clk(clk), .rst(rst), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .intAck(intAck), .cntClear(cntClear),
    .strobes(strobes), .delayCnt(delayCnt)
  );

  raster_irq_dpath #(
    .WRAP_AT(WRAP_AT), .LOW_LIMIT(LOW_LIMIT), .ACK_BIT(ACK_BIT)
  ) dpath_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .lineCnt(lineCnt), .irqOut(irqOut)
  );

endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk #(
  parameter int LINE_W  = 6,
  parameter int DELAY_W = 2,
  parameter int WRAP_AT = 52,
  parameter int ACK_BIT = 5,
  parameter int DELAY_LOAD = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               hsyncIn,
  input logic               vsyncIn,
  input logic               intAck,
  input logic               cntClear,
  input logic               irqOut,
  input logic [LINE_W-1:0]  lineCnt,
  input logic [DELAY_W-1:0] delayCnt
);

  AST_NO_FALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !($past(hsyncIn) && !hsyncIn) && !intAck && !cntClear |=> $stable(lineCnt)); // R1

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    {1'b0, lineCnt} < (LINE_W+1)'(WRAP_AT)); // R2

  AST_VS_LOAD: assert property (@(posedge clk) disable iff (rst)
    vsyncIn && !$past(vsyncIn) |=> delayCnt == DELAY_W'(DELAY_LOAD)); // R3

  AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (rst)
    delayCnt <= DELAY_W'(DELAY_LOAD)); // R4

  AST_ACK_BIT: assert property (@(posedge clk) disable iff (rst)
    intAck |=> !lineCnt[ACK_BIT]); // R6

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    intAck && !($past(hsyncIn) && !hsyncIn) |=> !irqOut); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    cntClear |=> lineCnt == '0); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    irqOut && !intAck |=> irqOut); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> !irqOut && lineCnt == '0 && delayCnt == '0); // R9

endmodule

bind raster_irq_gen raster_irq_chk #(
  .LINE_W(LINE_W), .DELAY_W(DELAY_W), .WRAP_AT(WRAP_AT),
  .ACK_BIT(ACK_BIT), .DELAY_LOAD(DELAY_LOAD)
) chk_i (
  .clk(clk), .rst(rst), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
  .intAck(intAck), .cntClear(cntClear), .irqOut(irqOut),
  .lineCnt(lineCnt), .delayCnt(delayCnt)
);

// File: tb/raster_irq_gen_tb.sv
`timescale 1ns/1ps
module raster_irq_gen_tb_top;

  logic clk = 1'b0;
  logic rst, hsyncIn, vsyncIn, intAck, cntClear;
  logic irqOut;

  int checks = 0;
  int fails  = 0;

  // Reference state
  int   mCnt = 0;
  int   mDly = 0;
  logic mIrq = 1'b0;
  logic mHs  = 1'b0;
  logic mVs  = 1'b0;

  always #2 clk = ~clk;

  raster_irq_gen dut_i (
    .clk(clk), .rst(rst), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .intAck(intAck), .cntClear(cntClear), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irqOut actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Next reference state from requirements R1..R8
  function automatic void modelStep(input logic hs, input logic vs,
                                    input logic ack, input logic clr);
    logic fall, rise, raise;
    int c, d;
    fall = mHs && !hs;   // R1
    rise = vs && !mVs;   // R3
    raise = 1'b0;
    c = mCnt;
    d = mDly;
    if (fall) begin
      c = c + 1;
      if (c == 52) begin raise = 1'b1; c = 0; end       // R2
      if (d != 0) begin
        d = d - 1;                                      // R4
        if (d == 0) begin
          if (c < 32) raise = 1'b1;                     // R5
          c = 0;
        end
      end
    end
    if (rise) d = 2;
    if (ack) c = c & ~32;                               // R6
    if (clr) c = 0;                                     // R7
    if (raise) mIrq = 1'b1;
    else if (ack) mIrq = 1'b0;                          // R8
    mCnt = c;
    mDly = d;
    mHs = hs;
    mVs = vs;
  endfunction

  // One clock: drive after negedge, result sampled at following negedge
  task automatic step(input logic hs, input logic vs, input logic ack,
                      input logic clr, input string req);
    hsyncIn = hs; vsyncIn = vs; intAck = ack; cntClear = clr;
    modelStep(hs, vs, ack, clr);
    @(negedge clk);
    check(req, irqOut, mIrq);
  endtask

  task automatic lines(input int n, input logic vs, input string req);
    for (int i = 0; i < n; i++) begin
      step(1'b1, vs, 1'b0, 1'b0, req);
      step(1'b0, vs, 1'b0, 1'b0, req);
    end
  endtask

  task automatic finishRun;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; hsyncIn = 1'b0; vsyncIn = 1'b0; intAck = 1'b0; cntClear = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R9 reset state", irqOut, 1'b0);

    // R2: 51 falls quiet, 52nd raises
    lines(51, 1'b0, "R1 count");
    check("R2 no request before 52", irqOut, 1'b0);
    lines(1, 1'b0, "R2 wrap");
    check("R2 request at 52", irqOut, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R8 hold");
    check("R8 level held", irqOut, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ack");
    check("R6 ack clears request", irqOut, 1'b0);

    // R3/R4/R5: resync with small count raises extra request
    step(1'b0, 1'b1, 1'b0, 1'b0, "R3 vsync rise");
    lines(1, 1'b1, "R4 first line");
    check("R4 no request after one line", irqOut, 1'b0);
    lines(1, 1'b1, "R5 resync");
    check("R5 resync below 32 raises", irqOut, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ack");

    // R5: resync at 42 raises nothing, count restarts at 0
    lines(40, 1'b0, "R1 count");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R3 vsync rise");
    lines(2, 1'b1, "R5 resync high");
    check("R5 resync at 42 silent", irqOut, 1'b0);
    lines(51, 1'b0, "R4 count from 0");
    check("R4 cleared count quiet at 51", irqOut, 1'b0);
    lines(1, 1'b0, "R4 wrap");
    check("R4 request 52 lines after resync", irqOut, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ack");

    // R6: ack at count 40 leaves 8
    lines(40, 1'b0, "R1 count");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ack bit5");
    lines(43, 1'b0, "R6 count from 8");
    check("R6 quiet at 51 after bit5 clear", irqOut, 1'b0);
    lines(1, 1'b0, "R6 wrap");
    check("R6 bit5 cleared on ack", irqOut, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ack");

    // R7: software clear
    lines(30, 1'b0, "R1 count");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R7 clear");
    lines(51, 1'b0, "R7 count from 0");
    check("R7 quiet at 51 after clear", irqOut, 1'b0);
    lines(1, 1'b0, "R7 wrap");
    check("R7 request after clear", irqOut, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6 ack");

    // Random mix: R1 R2 R3 R4 R5 R6 R7 R8 against the model
    for (int ln = 0; ln < 2500; ln++) begin
      logic vs;
      vs = ((ln % 61) < 3) || ($urandom_range(0, 99) == 0);
      for (int h = 0; h < $urandom_range(1, 3); h++)
        step(1'b1, vs, ($urandom_range(0, 39) == 0), 1'b0, "R1 R2 random");
      for (int l = 0; l < $urandom_range(1, 3); l++)
        step(1'b0, vs,
             (mIrq && $urandom_range(0, 3) == 0) || ($urandom_range(0, 49) == 0),
             ($urandom_range(0, 299) == 0), "R5 R6 R7 random");
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mCnt = 0; mDly = 0; mIrq = 1'b0;
    check("R9 reset clears request", irqOut, 1'b0);
    finishRun();
  end

endmodule